// File: doc/BRIEF.md
# Shared PWM Timebase Unit

This block is one of several shared timebase units that drive the channel stages of a multi-channel PWM. It picks one of two source clock enables: a fast one, or a slow one that stays alive in low-power states. It divides the selected ticks with a 16-bit prescaler and then steps an up-counting cycle timer. The cycle timer's count and a one-cycle period-start strobe go out to every channel stage. The channel stages compare the count against their duty values.

Software programs the unit through a byte-wide write port. The port holds the prescaler (as a low and a high byte), the cycle-timer terminal value, the upper terminal bits of the wide variant, and a control byte with the source select and the counter enable. Prescaler and terminal writes go to shadow registers. While the unit is running, the shadow values move into the active counters only at a period boundary. While it is stopped, they move in at once. The write port is a plain register strobe with no back-pressure: a write with `wr_en` high always lands in the cycle it is presented. No streaming data crosses this block, so it has no valid/ready pair.

The wide variant has extra terminal bits above the 8-bit terminal, and these reset to all ones. Once software clears them, the unit behaves exactly like an 8-bit cycle timer.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, `count` is 0 and `period_start` is 0. Reset loads these values: prescaler 0, terminal low byte 0xFF, extension bits all ones (a 10-bit terminal of 0x3FF by default), slow source selected, counting disabled.
- R2: While the enable bit (address 4, bit 1) is 0, `count` is held at 0 and `period_start` stays 0, whatever the source ticks do.
- R3: While running, the interval between strobes is (P+1)×(T+1) selected source ticks. P is the 16-bit prescaler, with its low byte at address 0 and its high byte at address 1. T is the terminal, with its low byte at address 2. P=0xFFFF with T=0 gives 65536 ticks.
- R4: Address 4, bit 0 selects the source: 1 uses `fast_tick` and 0 uses `slow_tick`. Ticks of the unselected source do not move `count`.
- R5: `count` goes up by one on each prescaled tick from 0 to T, then returns to 0. It never exceeds the active terminal.
- R6: `period_start` is high for exactly one cycle each time `count` wraps to 0, and it is high only while `count` is 0. The one exception is a period of one tick, where the strobe stays high.
- R7: A prescaler or terminal write made while running does not change the period in progress. The new value applies from the next period.
- R8: Address 3, bits [1:0] hold the terminal bits above bit 7. With these bits at their reset value the period is 1024 prescaled ticks. Once they are written to 0, the unit acts as an 8-bit timer and `count` never exceeds 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick | input | 1 | Single-cycle enable of the fast source clock |
| slow_tick | input | 1 | Single-cycle enable of the slow always-on source clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 prescaler low, 1 prescaler high, 2 terminal, 3 terminal upper bits, 4 control) |
| wr_data | input | 8 | Register write data |
| count | output | 10 | Current cycle-timer count, sent to all channel stages |
| period_start | output | 1 | One-cycle strobe at the start of each period |

## Verification
The bench measures strobe intervals for prescaler and terminal pairs at both ends of the range: a one-tick period where the strobe never drops, a high prescaler byte, and a divide of 65536. A design that swapped the byte lanes, or that counted to T instead of T+1, would show a wrong interval. A terminal rewritten mid-period must leave that period at its old length; a design that applied it at once would end the period early. The bench also checks that the wide variant gives 1024-tick periods out of reset and 256-tick periods once its upper bits are cleared. It checks that ticks of the unselected source and writes made while disabled leave `count` at rest.

// File: rtl/pwm_tmb_pkg.sv
package pwm_tmb_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PRE_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TERM     = 3'd2;
  localparam logic [ADDR_W-1:0] A_TERM_EXT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL     = 3'd4;
  localparam int CTRL_SRC_BIT = 0;
  localparam int CTRL_RUN_BIT = 1;
endpackage

// File: rtl/tmb_regs.sv
module tmb_regs
  import pwm_tmb_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CT_W  = 8,
  parameter int EXT_W = 2,
  parameter bit HAS_EXT = 1'b1,
  parameter logic [EXT_W-1:0] EXT_RST = {EXT_W{1'b1}}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  output logic [PRE_W-1:0]      pre_val,
  output logic [CT_W+EXT_W-1:0] term_val,
  output logic                  fast_sel,
  output logic                  run
);
  localparam int HI_W = PRE_W - 8;

  logic [CT_W-1:0]  term_lo;
  logic [EXT_W-1:0] term_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_val  <= '0;
      term_lo  <= '1;
      fast_sel <= 1'b0;
      run      <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PRE_LO: pre_val[7:0]       <= wr_data;
        A_PRE_HI: pre_val[PRE_W-1:8] <= wr_data[HI_W-1:0];
        A_TERM:   term_lo            <= wr_data[CT_W-1:0];
        A_CTRL: begin
          fast_sel <= wr_data[CTRL_SRC_BIT];
          run      <= wr_data[CTRL_RUN_BIT];
        end
        default: ;
      endcase
    end
  end

  generate
    if (HAS_EXT) begin : g_ext
      always_ff @(posedge clk) begin
        if (!rst_n)
          term_ext <= EXT_RST;
        else if (wr_en && wr_addr == A_TERM_EXT)
          term_ext <= wr_data[EXT_W-1:0];
      end
    end else begin : g_no_ext
      assign term_ext = '0;
    end
  endgenerate

  assign term_val = {term_ext, term_lo};
endmodule

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         step
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt == limit);
  assign step   = run && tick && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      cnt <= '0;
    else if (tick)
      cnt <= at_end ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/tmb_cycle_timer.sv
module tmb_cycle_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap,
  output logic         strobe
);
  assign wrap = step && (count == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      count  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= wrap;
      if (step)
        count <= wrap ? '0 : count + W'(1);
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tmb_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CT_W  = 8,
  parameter int EXT_W = 2,
  parameter bit HAS_EXT = 1'b1,
  parameter logic [EXT_W-1:0] EXT_RST = {EXT_W{1'b1}}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fast_tick,
  input  logic                  slow_tick,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic [CT_W+EXT_W-1:0] count,
  output logic                  period_start
);
  localparam int CNT_W = CT_W + EXT_W;
  localparam logic [EXT_W-1:0] EXT_INIT = HAS_EXT ? EXT_RST : '0;
  localparam logic [CNT_W-1:0] TERM_RST = {EXT_INIT, {CT_W{1'b1}}};

  logic [PRE_W-1:0] sh_pre, act_pre;
  logic [CNT_W-1:0] sh_term, act_term;
  logic             fast_sel, run, tick, step, wrap;

  tmb_regs #(
    .PRE_W(PRE_W), .CT_W(CT_W), .EXT_W(EXT_W),
    .HAS_EXT(HAS_EXT), .EXT_RST(EXT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pre_val(sh_pre), .term_val(sh_term),
    .fast_sel(fast_sel), .run(run)
  );

  assign tick = fast_sel ? fast_tick : slow_tick;

  // Shadow to active: immediately while stopped, else only at a wrap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pre  <= '0;
      act_term <= TERM_RST;
    end else if (!run || wrap) begin
      act_pre  <= sh_pre;
      act_term <= sh_term;
    end
  end

  tmb_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .limit(act_pre), .step(step)
  );

  tmb_cycle_timer #(.W(CNT_W)) u_ct (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step),
    .limit(act_term), .count(count), .wrap(wrap), .strobe(period_start)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fast_tick,
  input logic             slow_tick,
  input logic             run,
  input logic [CNT_W-1:0] count,
  input logic             period_start,
  input logic [CNT_W-1:0] act_term
);
  // R6
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (count == '0));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == '0)));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= act_term);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((count == '0) && !period_start));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_tick && !slow_tick) |=> ($stable(count) || (count == '0)));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
  .run(run), .count(count), .period_start(period_start), .act_term(act_term)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  typedef struct packed {
    logic [15:0] pre;
    logic [7:0]  term;
    logic        fast;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 8'h00, 1'b1, 32'd1},
    '{16'h0001, 8'h00, 1'b1, 32'd2},
    '{16'h0000, 8'h03, 1'b1, 32'd4},
    '{16'h0002, 8'h04, 1'b1, 32'd15},
    '{16'h0001, 8'h02, 1'b0, 32'd30},
    '{16'h0103, 8'h01, 1'b1, 32'd520},
    '{16'h0000, 8'hFF, 1'b1, 32'd256}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_tick = 1'b0;
  logic       slow_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [9:0] count;
  logic       period_start;
  logic [2:0] ph = '0;
  logic       slow_tick;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) ph <= (ph == 3'd4) ? 3'd0 : ph + 3'd1;
  assign slow_tick = slow_en && (ph == 3'd4);

  pwm_timebase dut (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .period_start(period_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Finds a strobe, then counts cycles to the next one; also tracks max count.
  task automatic measure(input int limit, output int per, output int maxc,
                         output int cnt_at, output bit st_next);
    int n;
    per = -1; maxc = 0; cnt_at = -1; st_next = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!period_start && n < limit);
    if (!period_start) return;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (int'(count) > maxc) maxc = int'(count);
    end while (!period_start && n < limit);
    if (!period_start) return;
    per = n;
    cnt_at = int'(count);
    @(negedge clk);
    st_next = period_start;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int per, maxc, cnt_at, n;
    bit st_next;
    bit quiet;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1 count after reset", int'(count), 0);
    chk(!period_start, "R1 strobe after reset", int'(period_start), 0);

    // R2 disabled: ticks present, nothing moves
    fast_tick = 1'b1;
    quiet = 1'b1;
    repeat (20) begin @(negedge clk); if (period_start || count != 0) quiet = 1'b0; end
    chk(quiet, "R2 idle while disabled", int'(count), 0);

    // R4 default slow source: enable only, fast ticks ignored
    slow_en = 1'b0;
    wr(3'd4, 8'h02);
    repeat (20) @(negedge clk);
    chk(count == 0, "R4 fast tick ignored with slow selected", int'(count), 0);
    fast_tick = 1'b0; slow_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(count == 4, "R4 slow ticks counted", int'(count), 4);
    wr(3'd4, 8'h00);
    @(negedge clk);
    chk(count == 0, "R2 disable clears count", int'(count), 0);

    // R8/R1 wide terminal out of reset: 1024-tick period
    fast_tick = 1'b1;
    wr(3'd4, 8'h03);
    measure(3000, per, maxc, cnt_at, st_next);
    chk(per == 1024, "R8 reset wide period", per, 1024);
    chk(maxc == 1023, "R8 reset wide max count", maxc, 1023);

    // R8 cleared upper bits: 8-bit behaviour
    wr(3'd4, 8'h01);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h03);
    measure(3000, per, maxc, cnt_at, st_next);
    chk(per == 256, "R8 cleared upper bits period", per, 256);
    chk(maxc == 255, "R8 cleared upper bits max count", maxc, 255);

    // R3/R5/R6 table of settings
    for (int i = 0; i < NV; i++) begin
      wr(3'd4, {7'd0, VECS[i].fast});
      wr(3'd0, VECS[i].pre[7:0]);
      wr(3'd1, VECS[i].pre[15:8]);
      wr(3'd2, VECS[i].term);
      wr(3'd4, {6'd0, 1'b1, VECS[i].fast});
      measure(2000, per, maxc, cnt_at, st_next);
      chk(per == int'(VECS[i].exp), "R3 period", per, int'(VECS[i].exp));
      chk(maxc == int'(VECS[i].term), "R5 max count", maxc, int'(VECS[i].term));
      chk(cnt_at == 0, "R6 count zero at strobe", cnt_at, 0);
      if (VECS[i].exp > 1)
        chk(!st_next, "R6 strobe one cycle", int'(st_next), 0);
      else
        chk(st_next, "R6 strobe stays high at one-tick period", int'(st_next), 1);
    end

    // R7 terminal change while running lands at the boundary
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'd9);
    wr(3'd4, 8'h03);
    measure(200, per, maxc, cnt_at, st_next);
    chk(per == 10, "R7 initial period", per, 10);
    n = 1;
    wr(3'd2, 8'd2);
    n += 2;
    do begin @(negedge clk); n++; end while (!period_start && n < 100);
    chk(n == 10, "R7 old period kept after mid-period write", n, 10);
    measure(200, per, maxc, cnt_at, st_next);
    chk(per == 3, "R7 new period after boundary", per, 3);

    // R3 largest prescaler
    wr(3'd4, 8'h01);
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h03);
    measure(70000, per, maxc, cnt_at, st_next);
    chk(per == 65536, "R3 prescaler 0xFFFF period", per, 65536);

    finish_run();
  end
endmodule